// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block sits on the receive path of an Ethernet MAC, right after the preamble is stripped. It takes the six destination address bytes of each frame, one byte per accepted beat and in wire order. It decides whether the frame is for this station, and it reports the class of the address (unicast, multicast or broadcast). For a multicast address it looks up a 64-bit hash table. The 6-bit table index is built up byte by byte from a reflected CRC-32 that runs while the bytes arrive.

Software programs the block through a small write port. The port holds three 16-bit station address words, four 16-bit hash words and a mode word. The mode word carries a receiver enable, a hash enable and a promiscuous flag. The address and hash words can only be written while the receiver is stopped. The `rx_running` status stays high until the receiver has really stopped, and software polls it before it reconfigures the block.

Byte input is valid/ready. `in_ready` equals `rx_running`. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold the byte steady while `in_ready` is low. Idle beats between bytes are allowed and stretch the decision by the same number of cycles. The decision outputs have no back-pressure: they form a one-cycle strobe.

Top module: `mcast_hash_addr_filter`

## Requirements
- R1: `dec_hash` equals bits 31..26 of a CRC. The CRC starts at 0xFFFFFFFF and runs over the six bytes in arrival order, each byte least significant bit first, with the reflected polynomial 0xEDB88320. The result is not inverted.
- R2: A multicast address has bit 0 of its first byte set. When hash enable is on, such an address is accepted exactly when the table bit it selects is 1. Index bits [5:4] choose hash word 0..3 (write addresses 3..6), and index bits [3:0] choose the bit inside that word.
- R3: A unicast address is accepted only when all 48 bits equal the station address. Word 0 at address 0 holds bytes 0/1, word 1 at address 1 holds bytes 2/3, and word 2 at address 2 holds bytes 4/5. The earlier byte sits in bits [15:8]. The hash table has no effect on unicast addresses.
- R4: The all-ones address is always accepted and is reported as `dec_kind` = 2. Other multicast addresses report 1 and unicast addresses report 0.
- R5: With promiscuous mode on (mode bit 2), every address is accepted.
- R6: With hash enable off (mode bit 1) and promiscuous mode off, every non-broadcast multicast address is rejected.
- R7: When all four hash words hold 0xFFFF and hash enable is on, every multicast address is accepted.
- R8: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth byte is taken. For back-to-back bytes this is 6 cycles after the first byte. Idle beats delay the pulse and do not end the address.
- R9: Writes to addresses 0..6 are ignored while `rx_running` is high. Writes to the mode word (address 7) always take effect.
- R10: `rx_running` is high while mode bit 0 (enable) is set. After enable is cleared partway through an address, `rx_running` stays high until that address has finished. `in_ready` follows `rx_running`.
- R11: After reset all registers are zero, and `rx_running`, `in_ready` and `dec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Word select: 0..2 station, 3..6 hash, 7 mode |
| cfg_wdata | input | 16 | Write data |
| rx_running | output | 1 | Receiver active; low only once fully stopped |
| in_valid | input | 1 | Address byte valid |
| in_ready | output | 1 | Filter takes a byte this cycle |
| in_byte | input | 8 | Destination address byte, wire order |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 2 | 0 unicast, 1 multicast, 2 broadcast |
| dec_hash | output | 6 | Hash index of the address |

## Verification
Two functions can meet in one clock edge: a mode-word write that clears the enable, and a byte being taken partway through an address. The bench drives both in the same cycle. It then checks that `rx_running` stays high for the remaining bytes, that the decision still arrives on time, and that the receiver reports stopped in the cycle after it. A second collision is a station or hash write issued while the receiver runs. The bench judges it through the port, by sending the old station address and a multicast address after the write.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  typedef enum logic [1:0] {
    KIND_UCAST = 2'd0,
    KIND_MCAST = 2'd1,
    KIND_BCAST = 2'd2
  } addr_kind_e;

  localparam int MODE_W       = 3;
  localparam int MODE_BIT_EN  = 0;
  localparam int MODE_BIT_HSH = 1;
  localparam int MODE_BIT_PRM = 2;
endpackage

// File: rtl/afilt_crc_byte.sv
module afilt_crc_byte #(
  parameter int          CRC_W = 32,
  parameter int          DW    = 8,
  parameter logic [31:0] POLY  = 32'hEDB88320
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [DW-1:0]    data,
  output logic [CRC_W-1:0] crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int j = 0; j < DW; j++) begin
      fb = c[0] ^ data[j];
      c  = c >> 1;
      if (fb) c = c ^ POLY[CRC_W-1:0];
    end
    crc_out = c;
  end
endmodule

// File: rtl/afilt_cfg.sv
module afilt_cfg
  import afilt_pkg::*;
#(
  parameter int N_BYTES    = 6,
  parameter int HASH_WORDS = 4,
  parameter int WORD_W     = 16,
  parameter int AW         = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic                       lock,
  output logic [N_BYTES*8-1:0]       station,
  output logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
  output logic [MODE_W-1:0]          mode
);
  localparam int STA_WORDS = N_BYTES * 8 / WORD_W;
  localparam int MODE_ADDR = (1 << AW) - 1;

  logic unused_mode_bits;
  assign unused_mode_bits = ^wdata[WORD_W-1:MODE_W];

  for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && !lock && waddr == AW'(w)) q <= wdata;
    end
    assign station[(STA_WORDS-1-w)*WORD_W +: WORD_W] = q;
  end

  for (genvar h = 0; h < HASH_WORDS; h++) begin : g_hash
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && !lock && waddr == AW'(STA_WORDS + h)) q <= wdata;
    end
    assign hash_tbl[h*WORD_W +: WORD_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= '0;
    else if (we && waddr == AW'(MODE_ADDR)) mode <= wdata[MODE_W-1:0];
  end
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
#(
  parameter int N_BYTES    = 6,
  parameter int HASH_WORDS = 4,
  parameter int WORD_W     = 16,
  parameter int HASH_BITS  = 6
) (
  input  logic [N_BYTES*8-1:0]         addr,
  input  logic [N_BYTES*8-1:0]         station,
  input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
  input  logic [HASH_BITS-1:0]         idx,
  input  logic                         hash_en,
  input  logic                         promisc,
  output logic                         accept,
  output addr_kind_e                   kind
);
  localparam int SEL_W = $clog2(HASH_WORDS);
  localparam int BIT_W = $clog2(WORD_W);

  logic               is_bc, is_mc, hit, uc_match;
  logic [SEL_W-1:0]   word_sel;
  logic [BIT_W-1:0]   bit_sel;
  logic [WORD_W-1:0]  word_val;

  assign word_sel = idx[HASH_BITS-1 -: SEL_W];
  assign bit_sel  = idx[BIT_W-1:0];
  assign word_val = hash_tbl[word_sel*WORD_W +: WORD_W];
  assign hit      = word_val[bit_sel];

  assign is_bc    = &addr;
  assign is_mc    = addr[N_BYTES*8-8];
  assign uc_match = (addr == station);

  always_comb begin
    if (is_bc)      kind = KIND_BCAST;
    else if (is_mc) kind = KIND_MCAST;
    else            kind = KIND_UCAST;
  end

  always_comb begin
    if (promisc || is_bc) accept = 1'b1;
    else if (is_mc)       accept = hash_en && hit;
    else                  accept = uc_match;
  end
endmodule

// File: rtl/mcast_hash_addr_filter.sv
module mcast_hash_addr_filter
  import afilt_pkg::*;
#(
  parameter int          N_BYTES    = 6,
  parameter int          HASH_WORDS = 4,
  parameter int          WORD_W     = 16,
  parameter int          CRC_W      = 32,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic        rx_running,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [1:0]  dec_kind,
  output logic [5:0]  dec_hash
);
  localparam int AW        = 3;
  localparam int ADDR_W    = N_BYTES * 8;
  localparam int HASH_BITS = $clog2(HASH_WORDS * WORD_W);
  localparam int CNT_W     = $clog2(N_BYTES);

  logic [ADDR_W-1:0]            station;
  logic [HASH_WORDS*WORD_W-1:0] hash_tbl;
  logic [MODE_W-1:0]            mode;
  logic                         mode_en, mode_hash, mode_prom;

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [CRC_W-1:0]  crc_q, crc_seed, crc_nx;
  logic              take, last;
  logic              acc_nx;
  addr_kind_e        kind_nx;
  logic [HASH_BITS-1:0] idx_nx;

  afilt_cfg #(
    .N_BYTES(N_BYTES), .HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W), .AW(AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .lock(rx_running), .station(station), .hash_tbl(hash_tbl), .mode(mode)
  );

  assign mode_en   = mode[MODE_BIT_EN];
  assign mode_hash = mode[MODE_BIT_HSH];
  assign mode_prom = mode[MODE_BIT_PRM];

  assign rx_running = mode_en || (cnt_q != '0);
  assign in_ready   = rx_running;
  assign take       = in_valid && in_ready;
  assign last       = take && (cnt_q == CNT_W'(N_BYTES - 1));

  assign crc_seed = (cnt_q == '0) ? '1 : crc_q;
  assign addr_nx  = {addr_q[ADDR_W-9:0], in_byte};

  afilt_crc_byte #(.CRC_W(CRC_W), .DW(8), .POLY(CRC_POLY)) u_crc (
    .crc_in(crc_seed), .data(in_byte), .crc_out(crc_nx)
  );

  assign idx_nx = crc_nx[CRC_W-1 -: HASH_BITS];

  afilt_decide #(
    .N_BYTES(N_BYTES), .HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W), .HASH_BITS(HASH_BITS)
  ) u_dec (
    .addr(addr_nx), .station(station), .hash_tbl(hash_tbl), .idx(idx_nx),
    .hash_en(mode_hash), .promisc(mode_prom), .accept(acc_nx), .kind(kind_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      crc_q  <= '0;
    end else if (take) begin
      cnt_q  <= last ? '0 : cnt_q + 1'b1;
      addr_q <= addr_nx;
      crc_q  <= crc_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_kind   <= 2'd0;
      dec_hash   <= '0;
    end else begin
      dec_valid <= last;
      if (last) begin
        dec_accept <= acc_nx;
        dec_kind   <= kind_nx;
        dec_hash   <= idx_nx;
      end
    end
  end
endmodule

// File: rtl/afilt_checker.sv
module afilt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_running,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [1:0]  dec_kind,
  input logic        mode_hash,
  input logic        mode_prom,
  input logic [47:0] station,
  input logic [63:0] hash_tbl
);
  AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R8
  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd2) |-> dec_accept); // R4
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_kind != 2'd3)); // R4
  AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode_prom)) |-> dec_accept); // R5
  AST_NOHASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'd1 && !$past(mode_hash) && !$past(mode_prom)) |-> !dec_accept); // R6
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_running) |-> ($stable(station) && $stable(hash_tbl))); // R9
endmodule

bind mcast_hash_addr_filter afilt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_running(rx_running), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .dec_kind(dec_kind), .mode_hash(mode_hash),
  .mode_prom(mode_prom), .station(station), .hash_tbl(hash_tbl)
);

// File: tb/mcast_hash_addr_filter_test.sv
module mcast_hash_addr_filter_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_addr = '0; logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0; logic [7:0] in_byte = '0;
  logic rx_running, in_ready, dec_valid, dec_accept;
  logic [1:0] dec_kind; logic [5:0] dec_hash;

  int n_chk = 0, n_bad = 0;
  logic [15:0] hw [4];
  logic [47:0] sta;

  always #(CLK_P/2) clk = ~clk;

  mcast_hash_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_running(rx_running), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind), .dec_hash(dec_hash)
  );

  function automatic logic [5:0] m_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47-8*b -: 8];
      for (int j = 0; j < 8; j++) begin
        logic t = d[j] ^ c[0];
        c = c >> 1;
        if (t) c = c ^ 32'hEDB88320;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic [1:0] m_kind(input logic [47:0] a);
    if (&a) return 2'd2;
    if (a[40]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic m_acc(input logic [47:0] a, input logic h, input logic p);
    logic [5:0] i = m_hash(a);
    if (p || (&a)) return 1'b1;
    if (a[40]) return h && hw[i[5:4]][i[3:0]];
    return a == sta;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = a[47-8*b -: 8];
      if (b < 5) for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0;
        chk("R8 no early strobe", {47'd0, dec_valid}, 48'd0);
      end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [47:0] a, input logic h, input logic p);
    send(a, 0);
    chk({tag, " valid"}, {47'd0, dec_valid}, 48'd1);
    chk({tag, " accept"}, {47'd0, dec_accept}, {47'd0, m_acc(a, h, p)});
    chk({tag, " kind"}, {46'd0, dec_kind}, {46'd0, m_kind(a)});
    chk("R1 hash", {42'd0, dec_hash}, {42'd0, m_hash(a)});
  endtask

  // {address, hash_en, promisc}
  localparam logic [49:0] VEC [10] = '{
    {48'h0211_2233_4455, 1'b1, 1'b0},
    {48'h0211_2233_4456, 1'b1, 1'b0},
    {48'h0411_2233_4455, 1'b1, 1'b0},
    {48'hFFFF_FFFF_FFFF, 1'b0, 1'b0},
    {48'h0100_5E00_0001, 1'b1, 1'b0},
    {48'h0100_5E7F_FFFA, 1'b1, 1'b0},
    {48'h0100_5E00_0001, 1'b0, 1'b0},
    {48'h0100_5E7F_FFFA, 1'b0, 1'b1},
    {48'h0A0B_0C0D_0E0F, 1'b0, 1'b1},
    {48'h3333_0000_0001, 1'b1, 1'b0}
  };

  initial begin
    #(CLK_P * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] ia;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 running", {47'd0, rx_running}, 48'd0);
    chk("R11 ready", {47'd0, in_ready}, 48'd0);
    chk("R11 valid", {47'd0, dec_valid}, 48'd0);

    sta = 48'h0211_2233_4455;
    wr(3'd0, 16'h0211); wr(3'd1, 16'h2233); wr(3'd2, 16'h4455);
    for (int k = 0; k < 4; k++) hw[k] = '0;
    ia = m_hash(48'h0100_5E00_0001);
    hw[ia[5:4]][ia[3:0]] = 1'b1;
    for (int k = 0; k < 4; k++) wr(3'(3 + k), hw[k]);

    foreach (VEC[v]) begin
      wr(3'd7, {13'd0, VEC[v][0], VEC[v][1], 1'b1});
      run_case($sformatf("R2 R3 R5 R6 vec%0d", v), VEC[v][49:2], VEC[v][1], VEC[v][0]);
    end

    // R9: station and hash writes ignored while running
    wr(3'd7, 16'h0003);
    wr(3'd2, 16'h9999);
    wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF);
    run_case("R9 station kept", sta, 1'b1, 1'b0);
    run_case("R9 hash kept", 48'h0100_5E7F_FFFA, 1'b1, 1'b0);

    // R8: idle beats stretch the decision
    send(48'h0211_2233_4455, 2);
    chk("R8 gapped valid", {47'd0, dec_valid}, 48'd1);
    chk("R8 gapped accept", {47'd0, dec_accept}, 48'd1);

    // R10: enable cleared mid-address in the same cycle as a byte
    for (int b = 0; b < 6; b++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = sta[47-8*b -: 8];
      if (b == 3) begin cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 16'h0000; end
      else cfg_we = 1'b0;
      if (b == 4) chk("R10 still running", {47'd0, rx_running}, 48'd1);
    end
    @(negedge clk); in_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 decision delivered", {47'd0, dec_valid}, 48'd1);
    chk("R10 stopped", {47'd0, rx_running}, 48'd0);
    chk("R10 ready low", {47'd0, in_ready}, 48'd0);

    // R7: all-ones table accepts every multicast
    for (int k = 0; k < 4; k++) begin hw[k] = 16'hFFFF; wr(3'(3 + k), 16'hFFFF); end
    wr(3'd7, 16'h0003);
    run_case("R7 mc a", 48'h0100_5E7F_FFFA, 1'b1, 1'b0);
    run_case("R7 mc b", 48'h3333_0000_0001, 1'b1, 1'b0);
    chk("R7 accept", {47'd0, dec_accept}, 48'd1);
    run_case("R3 unicast ignores table", 48'h0211_2233_4400, 1'b1, 1'b0);
    run_case("R4 broadcast", 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 single pulse", {47'd0, dec_valid}, 48'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule